// File: doc/BRIEF.md
# Memory Space Access Decoder

This block sits between a CPU's address generation and the on-chip memories. Each cycle it may take one request: a 24-bit address and an access type. The four access types are code fetch, direct data read, indirect or displacement data read, and write. From the pair it works out which resource serves the access: the register banks, on-chip data RAM, on-chip code memory, the configuration bytes, or the external bus. The chosen target appears as a registered one-hot select, one cycle after the request.

The decode depends on the access type as well as the address:

- **Fetches** that land in data storage or in the configuration window are refused with an execute fault.
- **Writes** aimed at code memory or the configuration window are refused with a write fault.
- **Code memory** is reachable as data only through indirect or displacement reads.
- **Fetches in the code range** depend on an external-access strap. The strap is sampled once, as reset is released, and the fetch goes on-chip only when the latched strap is 1.

Two parameters set the on-chip RAM size (512 or 1024 bytes) and the code memory size (0, 8 or 16 KB). The block also drives the fixed reset fetch address.

Top module: `mem_space_decoder`

## Requirements
- R1: `valid_o` repeats `req_valid_i` one clock later, and the decode outputs describe the request accepted on that edge.
- R2: `sel_o` is one-hot.
  - Bit encoding: bit 0 = register banks, bit 1 = data RAM, bit 2 = code memory, bit 3 = configuration bytes, bit 4 = external bus.
  - Exactly one bit is set for a valid request without a fault.
  - No bit is set when there is no request or when there is a fault.
- R3: Addresses 00:0000–00:001F select the register banks (bit 0) for any non-fetch access, and `bank_o` = address bits [4:3]. `bank_o` is 0 for every other result.
- R4: `bitaddr_o` is 1 exactly for non-fetch accesses to 00:0020–00:007F.
- R5: Addresses from 00:0020 up to the RAM size minus one select data RAM (bit 1) for reads and writes. A fetch anywhere in 00:0000 up to the RAM size minus one raises `exec_fault_o` and selects nothing.
- R6: Configuration window FF:FFF8–FF:FFFF.
  - Data reads of FF:FFF8 and FF:FFF9 select the configuration bytes (bit 3).
  - Data reads of FF:FFFA–FF:FFFF go to the external bus.
  - A fetch anywhere in the window raises `exec_fault_o`.
- R7: Code range, starting at FF:0000 and spanning the code size.
  - A fetch selects code memory (bit 2) when the latched strap is 1, and the external bus when it is 0.
  - An indirect/displacement read selects code memory.
  - A direct read goes to the external bus.
- R8: A write (type 3) to the code range or to the configuration window raises `write_fault_o` and selects nothing.
- R9: The strap is captured on the first clock edge after `rst_ni` rises. The captured value is shown on `strap_o` and held until the next reset, whatever `ext_strap_i` does afterwards.
- R10: Any address not claimed by an on-chip resource selects the external bus (bit 4) for every access type.
- R11: `reset_vec_o` is always FF:0000.
- R12: While in reset, `valid_o`, `sel_o` and both fault flags are 0.

Access-type encoding on `req_type_i`: 0 = fetch, 1 = direct read, 2 = indirect/displacement read, 3 = write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_strap_i | input | 1 | External-access strap, sampled at reset exit |
| req_valid_i | input | 1 | Request present this cycle |
| req_type_i | input | 2 | Access type (0 fetch, 1 direct, 2 indirect, 3 write) |
| req_addr_i | input | 24 | Access address |
| valid_o | output | 1 | Decode result valid |
| sel_o | output | 5 | One-hot target select |
| bank_o | output | 2 | Register bank number |
| bitaddr_o | output | 1 | Bit-addressable location hit |
| exec_fault_o | output | 1 | Illegal code fetch |
| write_fault_o | output | 1 | Illegal write |
| strap_o | output | 1 | Latched strap value |
| reset_vec_o | output | 24 | Reset fetch address |

## Verification
The assertions check, on every cycle, the properties that hold for any address:

- the valid signal trails the request by one clock;
- the select is one-hot, and is empty whenever a fault is raised;
- the two fault flags never fire together;
- the latched strap never changes once captured.

Only the bench's scenarios can show that a given address reaches the right target. Those scenarios cover the region edges (0x1F/0x20, 0x7F/0x80, the RAM top, the code top, FFF7/FFF8/FFF9/FFFA), the per-type routing of the code range, and the effect of the strap under both reset values after the input pin has changed.

// File: rtl/msd_pkg.sv
package msd_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH    = 2'd0,
    ACC_DIRECT   = 2'd1,
    ACC_INDIRECT = 2'd2,
    ACC_WRITE    = 2'd3
  } acc_e;

  localparam int TGT_N   = 5;
  localparam int TGT_REG = 0;
  localparam int TGT_RAM = 1;
  localparam int TGT_ROM = 2;
  localparam int TGT_CFG = 3;
  localparam int TGT_EXT = 4;

  typedef struct packed {
    logic [TGT_N-1:0] sel;
    logic [1:0]       bank;
    logic             bitaddr;
    logic             exec_fault;
    logic             write_fault;
  } dec_t;
endpackage

// File: rtl/msd_strap_latch.sv
module msd_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic strap_o
);
  logic armed_q, strap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      strap_q <= 1'b0;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      strap_q <= strap_i;
    end
  end

  assign strap_o = strap_q;

  // R9
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(strap_q));
endmodule

// File: rtl/msd_region_decode.sv
module msd_region_decode
  import msd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int RAM_BYTES = 1024,
  parameter int CODE_KB   = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        type_i,
  input  logic              strap_i,
  output dec_t              dec_o
);
  localparam logic [ADDR_W-1:0] REG_END   = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] BIT_END   = ADDR_W'(128);
  localparam logic [ADDR_W-1:0] RAM_END   = ADDR_W'(RAM_BYTES);
  localparam logic [ADDR_W-1:0] CODE_BASE = ADDR_W'(24'hFF0000);
  localparam logic [ADDR_W-1:0] CODE_END  = CODE_BASE + ADDR_W'(CODE_KB * 1024);
  localparam logic [ADDR_W-1:0] CFG_BASE  = ADDR_W'(24'hFFFFF8);
  localparam logic [ADDR_W-1:0] CFG_LAST  = ADDR_W'(24'hFFFFF9);

  acc_e acc;
  logic in_code;
  assign acc = acc_e'(type_i);

  generate
    if (CODE_KB == 0) begin : g_no_code
      assign in_code = 1'b0;
    end else begin : g_code
      assign in_code = (addr_i >= CODE_BASE) && (addr_i < CODE_END);
    end
  endgenerate

  always_comb begin
    dec_o = '0;
    if (addr_i < REG_END) begin
      if (acc == ACC_FETCH) dec_o.exec_fault = 1'b1;
      else begin
        dec_o.sel[TGT_REG] = 1'b1;
        dec_o.bank         = addr_i[4:3];
      end
    end else if (addr_i < RAM_END) begin
      if (acc == ACC_FETCH) dec_o.exec_fault = 1'b1;
      else begin
        dec_o.sel[TGT_RAM] = 1'b1;
        dec_o.bitaddr      = (addr_i < BIT_END);
      end
    end else if (addr_i >= CFG_BASE) begin
      if (acc == ACC_FETCH)      dec_o.exec_fault       = 1'b1;
      else if (acc == ACC_WRITE) dec_o.write_fault      = 1'b1;
      else if (addr_i <= CFG_LAST) dec_o.sel[TGT_CFG]   = 1'b1;
      else                       dec_o.sel[TGT_EXT]     = 1'b1;
    end else if (in_code) begin
      unique case (acc)
        ACC_WRITE:    dec_o.write_fault   = 1'b1;
        ACC_FETCH:    dec_o.sel[strap_i ? TGT_ROM : TGT_EXT] = 1'b1;
        ACC_INDIRECT: dec_o.sel[TGT_ROM]  = 1'b1;
        default:      dec_o.sel[TGT_EXT]  = 1'b1;
      endcase
    end else begin
      dec_o.sel[TGT_EXT] = 1'b1;
    end
  end
endmodule

// File: rtl/msd_out_reg.sv
module msd_out_reg
  import msd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  dec_t dec_i,
  output logic valid_o,
  output dec_t dec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dec_o   <= '0;
    end else begin
      valid_o <= valid_i;
      dec_o   <= valid_i ? dec_i : '0;
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  // R2
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !dec_o.exec_fault && !dec_o.write_fault) |-> $countones(dec_o.sel) == 1);
  // R2
  idle_no_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> dec_o.sel == '0);
  // R5
  exec_no_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o.exec_fault |-> (dec_o.sel == '0 && !dec_o.write_fault));
  // R8
  write_no_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o.write_fault |-> dec_o.sel == '0);
endmodule

// File: rtl/mem_space_decoder.sv
module mem_space_decoder
  import msd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int RAM_BYTES = 1024,
  parameter int CODE_KB   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_strap_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_type_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              valid_o,
  output logic [TGT_N-1:0]  sel_o,
  output logic [1:0]        bank_o,
  output logic              bitaddr_o,
  output logic              exec_fault_o,
  output logic              write_fault_o,
  output logic              strap_o,
  output logic [ADDR_W-1:0] reset_vec_o
);
  dec_t dec_d, dec_q;
  logic strap_q;

  msd_strap_latch i_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (ext_strap_i),
    .strap_o (strap_q)
  );

  msd_region_decode #(
    .ADDR_W    (ADDR_W),
    .RAM_BYTES (RAM_BYTES),
    .CODE_KB   (CODE_KB)
  ) i_dec (
    .addr_i  (req_addr_i),
    .type_i  (req_type_i),
    .strap_i (strap_q),
    .dec_o   (dec_d)
  );

  msd_out_reg i_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .dec_i   (dec_d),
    .valid_o (valid_o),
    .dec_o   (dec_q)
  );

  assign sel_o         = dec_q.sel;
  assign bank_o        = dec_q.bank;
  assign bitaddr_o     = dec_q.bitaddr;
  assign exec_fault_o  = dec_q.exec_fault;
  assign write_fault_o = dec_q.write_fault;
  assign strap_o       = strap_q;
  assign reset_vec_o   = ADDR_W'(24'hFF0000);

  // R12
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && sel_o == '0 && !exec_fault_o && !write_fault_o));
endmodule

// File: tb/test_mem_space_decoder.sv
module test_mem_space_decoder;
  localparam int RAM_BYTES = 1024;
  localparam int CODE_KB   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        rv = 1'b0;
  logic [1:0]  rt = 2'd0;
  logic [23:0] ra = 24'd0;
  logic        valid_o, bitaddr_o, ef_o, wf_o, strap_o;
  logic [4:0]  sel_o;
  logic [1:0]  bank_o;
  logic [23:0] rvec_o;

  int checks = 0, fails = 0;
  bit strap_exp = 1'b0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  mem_space_decoder #(.RAM_BYTES(RAM_BYTES), .CODE_KB(CODE_KB)) i_mem_space_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ext_strap_i(strap), .req_valid_i(rv),
    .req_type_i(rt), .req_addr_i(ra), .valid_o(valid_o), .sel_o(sel_o),
    .bank_o(bank_o), .bitaddr_o(bitaddr_o), .exec_fault_o(ef_o),
    .write_fault_o(wf_o), .strap_o(strap_o), .reset_vec_o(rvec_o));

  // expected {sel[4:0], bank[1:0], bitaddr, exec_fault, write_fault}
  function automatic logic [9:0] model(input logic [1:0] t, input logic [23:0] a, input bit s);
    logic [4:0] sel = '0; logic [1:0] bk = '0; logic ba = 0, ef = 0, wf = 0;
    if (a < 24'd32) begin
      if (t == 2'd0) ef = 1; else begin sel = 5'b00001; bk = a[4:3]; end
    end else if (a < 24'(RAM_BYTES)) begin
      if (t == 2'd0) ef = 1; else begin sel = 5'b00010; ba = (a < 24'd128); end
    end else if (a >= 24'hFFFFF8) begin
      if (t == 2'd0) ef = 1;
      else if (t == 2'd3) wf = 1;
      else if (a <= 24'hFFFFF9) sel = 5'b01000;
      else sel = 5'b10000;
    end else if (CODE_KB != 0 && a >= 24'hFF0000 && a < 24'hFF0000 + 24'(CODE_KB*1024)) begin
      if (t == 2'd3) wf = 1;
      else if (t == 2'd0) sel = s ? 5'b00100 : 5'b10000;
      else if (t == 2'd2) sel = 5'b00100;
      else sel = 5'b10000;
    end else sel = 5'b10000;
    return {sel, bk, ba, ef, wf};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic req(input string tag, input logic [1:0] t, input logic [23:0] a);
    @(negedge clk);
    rv = 1'b1; rt = t; ra = a;
    exp_q.push_back(model(t, a, strap_exp));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    rv = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 unexpected valid actual=1 expected=0");
      end else begin
        logic [9:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(tg, 32'({sel_o, bank_o, bitaddr_o, ef_o, wf_o}), 32'(e));
      end
    end
  end

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst_n = 1'b0; rv = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    chk("R12 valid in reset", 32'(valid_o), 0);
    chk("R12 sel in reset", 32'(sel_o), 0);
    chk("R12 faults in reset", 32'({ef_o, wf_o}), 0);
    rst_n = 1'b1;
    strap_exp = s;
    repeat (2) @(negedge clk);
    strap = ~s;
    repeat (2) @(negedge clk);
    chk("R9 strap held", 32'(strap_o), 32'(s));
  endtask

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    chk("R11 reset vector", 32'(rvec_o), 32'h00FF0000);
    chk("R1 idle valid", 32'(valid_o), 0);
    // R3 register banks
    req("R3 bank0", 2'd1, 24'h000000);
    req("R3 bank1", 2'd3, 24'h00000A);
    req("R3 bank3 top", 2'd2, 24'h00001F);
    req("R5 fetch regfile", 2'd0, 24'h000010);
    // R4 / R5 data RAM edges
    req("R4 bit low", 2'd1, 24'h000020);
    req("R4 bit high", 2'd3, 24'h00007F);
    req("R4 past bit", 2'd2, 24'h000080);
    req("R5 ram top", 2'd3, 24'(RAM_BYTES-1));
    req("R5 fetch ram", 2'd0, 24'h000050);
    req("R10 above ram", 2'd1, 24'(RAM_BYTES));
    idle();
    // R7 / R8 code range
    req("R7 fetch base", 2'd0, 24'hFF0000);
    req("R7 indirect", 2'd2, 24'hFF1234);
    req("R7 direct", 2'd1, 24'hFF1234);
    req("R8 write code", 2'd3, 24'hFF0100);
    req("R7 code top", 2'd0, 24'hFF0000 + 24'(CODE_KB*1024-1));
    req("R10 past code", 2'd0, 24'hFF0000 + 24'(CODE_KB*1024));
    // R6 config window
    req("R10 below cfg", 2'd1, 24'hFFFFF7);
    req("R6 cfg0", 2'd1, 24'hFFFFF8);
    req("R6 cfg1", 2'd2, 24'hFFFFF9);
    req("R6 reserved", 2'd2, 24'hFFFFFA);
    req("R6 fetch cfg", 2'd0, 24'hFFFFF9);
    req("R6 fetch reserved", 2'd0, 24'hFFFFFF);
    req("R8 write cfg", 2'd3, 24'hFFFFF8);
    req("R8 write reserved", 2'd3, 24'hFFFFFC);
    req("R10 mid space", 2'd0, 24'h123456);
    req("R10 write ext", 2'd3, 24'h010000);
    idle();
    repeat (3) @(negedge clk);
    // strap 0 case
    do_reset(1'b0);
    req("R7 fetch strap0", 2'd0, 24'hFF0000);
    req("R7 indirect strap0", 2'd2, 24'hFF0800);
    req("R9 fetch after pin change", 2'd0, 24'hFF2000);
    idle();
    repeat (3) @(negedge clk);
    chk("R1 queue drained", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule